// File: doc/BRIEF.md
# Receive Destination and Source Address Filter

This block watches the start of each received Ethernet frame as a byte stream. The first received byte is marked by a start flag. From the first twelve header bytes it takes the destination address (bytes 0 to 5) and the source address (bytes 6 to 11). It then decides whether the frame should be kept. Several sources feed that decision:

- a set of destination perfect-match filters, each with its own per-byte mask;
- a set of masked source comparisons;
- a 64-entry hash table indexed by a CRC of the destination address;
- a mode that accepts every multicast destination;
- a promiscuous mode that accepts everything.

The decision comes with a status vector that tells the frame buffer which filters fired. The downstream buffer can then forward or discard the frame and keep the status with it.

The number of destination and source filters are parameters. The configuration is presented as flat vectors. In each filter, byte `i` of an address occupies bits `[8*i+7:8*i]` and corresponds to the `i`-th received byte of that address field.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid`, `dec_pass` and every status output are 0, and they stay 0 until a frame header has been received.
- R2: A byte is taken on a rising edge where `in_valid` is 1. The byte taken with `in_sof`=1 is header byte 0. `dec_valid` goes to 1 on the edge after header byte 11 is taken, not earlier. It then holds, with `dec_pass` and all status outputs unchanged, until the next start byte.
- R3: The edge after a byte is taken with `in_sof`=1 clears `dec_valid`, `dec_pass` and all status outputs. The following are ignored:
  - cycles with `in_valid`=0, whatever `in_sof` is;
  - bytes after header byte 11 that arrive without a new start.
- R4: Destination filter k fires (`st_da_hit[k]`) when `cfg_da_en[k]`=1 and, for every byte i from 0 to 5 whose mask bit `cfg_da_mask[6*k+i]` is 0, header byte i equals `cfg_da_addr[48*k+8*i +: 8]`. A mask bit of 1 removes that byte from the comparison.
- R5: Source filter j fires (`st_sa_hit[j]`) when `cfg_sa_en[j]`=1 and every byte i whose mask bit `cfg_sa_mask[6*j+i]` is 0 satisfies: header byte 6+i equals `cfg_sa_addr[48*j+8*i +: 8]`.
- R6: `st_hash_hit` equals `cfg_hash_tbl[idx]`. The index is found as follows:
  - a 32-bit register starts at all ones;
  - the register takes destination bytes 0 to 5 in order, each byte least significant bit first, as a right-shifting CRC with reflected polynomial 0xEDB88320 and no final inversion;
  - `idx` is bits [31:26] of the result.
- R7: `st_mcast` is bit 0 of header byte 0.
- R8: When promiscuous mode is off, `dec_pass` = (any destination hit, or `cfg_hash_en` with a hash hit, or `cfg_pass_mcast` with a multicast destination) and (`cfg_sa_filter`=0 or any source hit).
- R9: With `cfg_promisc`=1 the frame passes whatever the filters report, and the status outputs still show the filter results.
- R10: Configuration is sampled on the edge that takes header byte 11. Later configuration changes do not alter a decision already presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Received byte |
| cfg_da_addr | input | 48*NUM_DA | Destination perfect-match addresses |
| cfg_da_mask | input | 6*NUM_DA | Per-byte exclusion masks for destination filters |
| cfg_da_en | input | NUM_DA | Enable per destination filter |
| cfg_sa_addr | input | 48*NUM_SA | Source comparison addresses |
| cfg_sa_mask | input | 6*NUM_SA | Per-byte exclusion masks for source filters |
| cfg_sa_en | input | NUM_SA | Enable per source filter |
| cfg_sa_filter | input | 1 | Require a source hit to pass |
| cfg_hash_tbl | input | 64 | Hash table bits |
| cfg_hash_en | input | 1 | Let a hash hit pass the frame |
| cfg_pass_mcast | input | 1 | Pass every multicast destination |
| cfg_promisc | input | 1 | Pass all frames |
| dec_valid | output | 1 | Decision and status are valid |
| dec_pass | output | 1 | Frame accepted |
| st_da_hit | output | NUM_DA | Destination filters that fired |
| st_sa_hit | output | NUM_SA | Source filters that fired |
| st_hash_hit | output | 1 | Hash table bit selected by the destination |
| st_mcast | output | 1 | Destination is multicast |

## Verification
The hardest case to reach from the ports is a destination that differs from a filter only in bytes that are masked. Hitting it needs every mask pattern to be paired with every pattern of differing bytes. The bench sweeps all 64 masks against all 64 byte-difference patterns on one filter, which covers every masked/unmasked combination. It runs a similar sweep on each source filter. For the hash table, random destinations are sent and the index is computed arithmetically in the bench, so that many of the 64 table bits are visited. Idle cycles with a stray start flag are inserted into some headers, and configuration is changed after a decision to confirm that the held result does not move.

// File: rtl/raf_pkg.sv
package raf_pkg;
   localparam int ADDR_BYTES = 6;
   localparam int HDR_BYTES  = 2 * ADDR_BYTES;
   localparam int HASH_SIZE  = 64;
   localparam int HASH_IDX_W = $clog2(HASH_SIZE);
   localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;

   typedef logic [8*ADDR_BYTES-1:0] mac_addr_t;

   // One byte through a reflected CRC-32 register, least significant bit first.
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         r = (r >> 1) ^ ((r[0] ^ d[b]) ? CRC_POLY_REV : 32'h0);
      end
      return r;
   endfunction
endpackage

// File: rtl/raf_addr_match.sv
module raf_addr_match #(
   parameter int NBYTES = 6
) (
   input  logic [8*NBYTES-1:0] addr,
   input  logic [8*NBYTES-1:0] ref_addr,
   input  logic [NBYTES-1:0]   byte_mask,
   input  logic                enable,
   output logic                hit
);
   logic [NBYTES-1:0] byte_ok;

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign byte_ok[i] = byte_mask[i] | (addr[8*i +: 8] == ref_addr[8*i +: 8]);
   end

   assign hit = enable & (&byte_ok);
endmodule

// File: rtl/raf_hash_lookup.sv
module raf_hash_lookup
   import raf_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           data,
   input  logic                 start,
   input  logic                 feed,
   input  logic [HASH_SIZE-1:0] table_bits,
   output logic                 hit
);
   logic [31:0]           crc_q;
   logic [HASH_IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (start) begin
         crc_q <= crc_step_byte(32'hFFFF_FFFF, data);
      end else if (feed) begin
         crc_q <= crc_step_byte(crc_q, data);
      end
   end

   assign idx = crc_q[31 -: HASH_IDX_W];
   assign hit = table_bits[idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import raf_pkg::*;
#(
   parameter int NUM_DA = 4,
   parameter int NUM_SA = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sof,
   input  logic [7:0]               in_byte,
   input  logic [48*NUM_DA-1:0]     cfg_da_addr,
   input  logic [6*NUM_DA-1:0]      cfg_da_mask,
   input  logic [NUM_DA-1:0]        cfg_da_en,
   input  logic [48*NUM_SA-1:0]     cfg_sa_addr,
   input  logic [6*NUM_SA-1:0]      cfg_sa_mask,
   input  logic [NUM_SA-1:0]        cfg_sa_en,
   input  logic                     cfg_sa_filter,
   input  logic [63:0]              cfg_hash_tbl,
   input  logic                     cfg_hash_en,
   input  logic                     cfg_pass_mcast,
   input  logic                     cfg_promisc,
   output logic                     dec_valid,
   output logic                     dec_pass,
   output logic [NUM_DA-1:0]        st_da_hit,
   output logic [NUM_SA-1:0]        st_sa_hit,
   output logic                     st_hash_hit,
   output logic                     st_mcast
);
   localparam int CAP_BYTES = HDR_BYTES - 1;
   localparam int CNT_W     = $clog2(HDR_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_BYTES - 1);
   localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(CAP_BYTES);
   localparam logic [CNT_W-1:0] CNT_DA   = CNT_W'(ADDR_BYTES);
   localparam int ABITS = 8 * ADDR_BYTES;

   initial begin
      assert (NUM_DA >= 1 && NUM_DA <= 4) else $error("NUM_DA out of range");
      assert (NUM_SA >= 1 && NUM_SA <= 3) else $error("NUM_SA out of range");
      assert (HASH_SIZE == 64) else $error("hash table must have 64 entries");
   end

   logic [CNT_W-1:0]       cnt_q;
   logic [8*CAP_BYTES-1:0] hdr_q;
   logic                   sof_take, body_take, last_take;
   mac_addr_t              da_now, sa_now;
   logic [NUM_DA-1:0]      da_hits;
   logic [NUM_SA-1:0]      sa_hits;
   logic                   hash_hit, mcast_now, da_ok, sa_ok, pass_now;

   assign sof_take  = in_valid & in_sof;
   assign body_take = in_valid & ~in_sof & (cnt_q < CNT_IDLE);
   assign last_take = body_take & (cnt_q == CNT_LAST);

   // Header capture: bytes 0..10 stored, byte 11 used straight from the input.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_IDLE;
         hdr_q <= '0;
      end else if (sof_take) begin
         hdr_q[7:0] <= in_byte;
         cnt_q      <= CNT_W'(1);
      end else if (body_take) begin
         if (cnt_q < CNT_CAP) hdr_q[8*cnt_q +: 8] <= in_byte;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign da_now    = hdr_q[ABITS-1:0];
   assign sa_now    = {in_byte, hdr_q[8*CAP_BYTES-1:ABITS]};
   assign mcast_now = hdr_q[0];

   for (genvar k = 0; k < NUM_DA; k++) begin : g_da
      raf_addr_match #(.NBYTES(ADDR_BYTES)) u_match (
         .addr      (da_now),
         .ref_addr  (cfg_da_addr[ABITS*k +: ABITS]),
         .byte_mask (cfg_da_mask[ADDR_BYTES*k +: ADDR_BYTES]),
         .enable    (cfg_da_en[k]),
         .hit       (da_hits[k])
      );
   end

   for (genvar j = 0; j < NUM_SA; j++) begin : g_sa
      raf_addr_match #(.NBYTES(ADDR_BYTES)) u_match (
         .addr      (sa_now),
         .ref_addr  (cfg_sa_addr[ABITS*j +: ABITS]),
         .byte_mask (cfg_sa_mask[ADDR_BYTES*j +: ADDR_BYTES]),
         .enable    (cfg_sa_en[j]),
         .hit       (sa_hits[j])
      );
   end

   raf_hash_lookup u_hash (
      .clk        (clk),
      .rst_n      (rst_n),
      .data       (in_byte),
      .start      (sof_take),
      .feed       (body_take & (cnt_q < CNT_DA)),
      .table_bits (cfg_hash_tbl),
      .hit        (hash_hit)
   );

   assign da_ok    = (|da_hits) | (cfg_hash_en & hash_hit) | (cfg_pass_mcast & mcast_now);
   assign sa_ok    = ~cfg_sa_filter | (|sa_hits);
   assign pass_now = cfg_promisc | (da_ok & sa_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         dec_pass    <= 1'b0;
         st_da_hit   <= '0;
         st_sa_hit   <= '0;
         st_hash_hit <= 1'b0;
         st_mcast    <= 1'b0;
      end else if (sof_take) begin
         dec_valid   <= 1'b0;
         dec_pass    <= 1'b0;
         st_da_hit   <= '0;
         st_sa_hit   <= '0;
         st_hash_hit <= 1'b0;
         st_mcast    <= 1'b0;
      end else if (last_take) begin
         dec_valid   <= 1'b1;
         dec_pass    <= pass_now;
         st_da_hit   <= da_hits;
         st_sa_hit   <= sa_hits;
         st_hash_hit <= hash_hit;
         st_mcast    <= mcast_now;
      end
   end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
   parameter int NUM_DA = 4,
   parameter int NUM_SA = 3,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sof,
   input logic [CNT_W-1:0]  cnt,
   input logic              cfg_promisc,
   input logic              cfg_sa_filter,
   input logic              dec_valid,
   input logic              dec_pass,
   input logic [NUM_DA-1:0] st_da_hit,
   input logic [NUM_SA-1:0] st_sa_hit,
   input logic              st_hash_hit,
   input logic              st_mcast
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(raf_pkg::HDR_BYTES - 1);

   assert_valid_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(in_valid && !in_sof && cnt == LAST));

   assert_hold_until_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && !(in_valid && in_sof) |=>
         dec_valid && $stable(dec_pass) && $stable(st_da_hit) && $stable(st_sa_hit)
         && $stable(st_hash_hit) && $stable(st_mcast));

   assert_sof_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_sof |=> !dec_valid && !dec_pass && st_da_hit == '0 && st_sa_hit == '0);

   assert_da_hit_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) && (|st_da_hit) && $past(!cfg_sa_filter) |-> dec_pass);

   assert_promisc_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) && $past(cfg_promisc) |-> dec_pass);
endmodule

bind rx_addr_filter raf_checker #(.NUM_DA(NUM_DA), .NUM_SA(NUM_SA), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_sof        (in_sof),
   .cnt           (cnt_q),
   .cfg_promisc   (cfg_promisc),
   .cfg_sa_filter (cfg_sa_filter),
   .dec_valid     (dec_valid),
   .dec_pass      (dec_pass),
   .st_da_hit     (st_da_hit),
   .st_sa_hit     (st_sa_hit),
   .st_hash_hit   (st_hash_hit),
   .st_mcast      (st_mcast)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   localparam int ND = 4;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic [48*ND-1:0] cfg_da_addr;
   logic [6*ND-1:0]  cfg_da_mask;
   logic [ND-1:0]    cfg_da_en;
   logic [48*NS-1:0] cfg_sa_addr;
   logic [6*NS-1:0]  cfg_sa_mask;
   logic [NS-1:0]    cfg_sa_en;
   logic cfg_sa_filter, cfg_hash_en, cfg_pass_mcast, cfg_promisc;
   logic [63:0] cfg_hash_tbl;
   logic dec_valid, dec_pass, st_hash_hit, st_mcast;
   logic [ND-1:0] st_da_hit;
   logic [NS-1:0] st_sa_hit;

   int tests = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rx_addr_filter #(.NUM_DA(ND), .NUM_SA(NS)) u_dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [47:0] spread(input logic [5:0] p);
      logic [47:0] r = '0;
      for (int i = 0; i < 6; i++) if (p[i]) r[8*i+7] = 1'b1;
      return r;
   endfunction

   function automatic logic [5:0] hash_idx(input logic [47:0] da);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[0] ^ da[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c[31:26];
   endfunction

   function automatic logic [ND-1:0] exp_da(input logic [47:0] da);
      logic [ND-1:0] h;
      for (int k = 0; k < ND; k++) begin
         h[k] = cfg_da_en[k];
         for (int i = 0; i < 6; i++)
            if (!cfg_da_mask[6*k+i] && da[8*i +: 8] != cfg_da_addr[48*k+8*i +: 8]) h[k] = 1'b0;
      end
      return h;
   endfunction

   function automatic logic [NS-1:0] exp_sa(input logic [47:0] sa);
      logic [NS-1:0] h;
      for (int j = 0; j < NS; j++) begin
         h[j] = cfg_sa_en[j];
         for (int i = 0; i < 6; i++)
            if (!cfg_sa_mask[6*j+i] && sa[8*i +: 8] != cfg_sa_addr[48*j+8*i +: 8]) h[j] = 1'b0;
      end
      return h;
   endfunction

   // Sends one header and checks the decision one cycle after byte 11.
   task automatic send(input logic [47:0] da, input logic [47:0] sa, input bit gap);
      logic [95:0] f = {sa, da};
      logic [ND-1:0] eda = exp_da(da);
      logic [NS-1:0] esa = exp_sa(sa);
      logic ehash = cfg_hash_tbl[hash_idx(da)];
      logic emc = da[0];
      logic epass = cfg_promisc |
         (((|eda) | (cfg_hash_en & ehash) | (cfg_pass_mcast & emc)) & (!cfg_sa_filter | (|esa)));
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (i == 1) chk(dec_valid == 1'b0, "R3", "valid cleared by start", 64'(dec_valid), 0);
         if (i == 11) chk(dec_valid == 1'b0, "R2", "valid not early", 64'(dec_valid), 0);
         in_valid = 1'b1; in_sof = (i == 0); in_byte = f[8*i +: 8];
         if (gap && (i % 3 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b1; in_byte = 8'hC3;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
      chk(dec_valid == 1'b1, "R2", "valid after byte 11", 64'(dec_valid), 1);
      chk(st_da_hit == eda, "R4", "da hits", 64'(st_da_hit), 64'(eda));
      chk(st_sa_hit == esa, "R5", "sa hits", 64'(st_sa_hit), 64'(esa));
      chk(st_hash_hit == ehash, "R6", "hash hit", 64'(st_hash_hit), 64'(ehash));
      chk(st_mcast == emc, "R7", "multicast", 64'(st_mcast), 64'(emc));
      chk(dec_pass == epass, cfg_promisc ? "R9" : "R8", "pass", 64'(dec_pass), 64'(epass));
   endtask

   // Hold test: cfg changes and sof-less bytes must not disturb the result.
   task automatic hold_check();
      logic p = dec_pass;
      logic [ND-1:0] d = st_da_hit;
      logic h = st_hash_hit;
      cfg_promisc = ~cfg_promisc; cfg_hash_tbl = ~cfg_hash_tbl; cfg_da_en = ~cfg_da_en;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_byte = 8'(i * 37);
      end
      @(negedge clk); in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(dec_valid && dec_pass == p && st_da_hit == d && st_hash_hit == h, "R10",
          "decision held", {62'(0), dec_valid, dec_pass}, {62'(0), 1'b1, p});
      cfg_promisc = ~cfg_promisc; cfg_hash_tbl = ~cfg_hash_tbl; cfg_da_en = ~cfg_da_en;
   endtask

   initial begin
      cfg_da_addr = {48'h0A1B2C3D4E5F, 48'h665544332211, 48'hFFEEDDCCBBAA, 48'h123456789ABC};
      cfg_da_mask = '0; cfg_da_en = '0;
      cfg_sa_addr = {48'h0F0E0D0C0B0A, 48'hA0B0C0D0E0F0, 48'h3C2B1A0F9E8D};
      cfg_sa_mask = '0; cfg_sa_en = '0;
      cfg_sa_filter = 0; cfg_hash_en = 0; cfg_pass_mcast = 0; cfg_promisc = 0;
      cfg_hash_tbl = 64'h0;
      repeat (3) @(negedge clk);
      chk(dec_valid == 0 && dec_pass == 0 && st_da_hit == 0 && st_sa_hit == 0, "R1",
          "reset state", {62'(0), dec_valid, dec_pass}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dec_valid == 0 && st_hash_hit == 0 && st_mcast == 0, "R1", "idle after reset",
          64'(dec_valid), 0);

      // R4: every mask against every pattern of differing bytes on filter 0
      cfg_da_en = 4'b0001;
      for (int m = 0; m < 64; m++) begin
         cfg_da_mask[5:0] = 6'(m);
         for (int p = 0; p < 64; p++)
            send(cfg_da_addr[47:0] ^ spread(6'(p)), 48'h1122334455AA, ((m + p) % 7) == 0);
      end
      cfg_da_mask = '0;

      // R4: each filter on its own, exact and one-byte-off
      for (int k = 0; k < ND; k++) begin
         cfg_da_en = ND'(1) << k;
         send(cfg_da_addr[48*k +: 48], 48'h0, 0);
         send(cfg_da_addr[48*k +: 48] ^ spread(6'(1) << (k % 6)), 48'h0, 0);
      end
      hold_check();

      // R5: source sweep per filter, distinct masks
      cfg_da_en = '0; cfg_sa_en = 3'b111; cfg_sa_filter = 1;
      cfg_sa_mask = {6'b100001, 6'b000110, 6'b000000};
      for (int j = 0; j < NS; j++)
         for (int p = 0; p < 64; p++)
            send(48'h000000000002, cfg_sa_addr[48*j +: 48] ^ spread(6'(p)), p == 5);
      cfg_sa_filter = 0; cfg_sa_en = '0; cfg_sa_mask = '0;

      // R6: hash table with random destinations
      cfg_hash_en = 1; cfg_hash_tbl = {$urandom, $urandom};
      for (int n = 0; n < 300; n++) send({$urandom, 16'($urandom)}, 48'h0, 0);

      // R7/R8/R9: all mode combinations with mixed frames
      cfg_da_en = 4'b0101; cfg_sa_en = 3'b011;
      for (int md = 0; md < 16; md++) begin
         {cfg_promisc, cfg_pass_mcast, cfg_hash_en, cfg_sa_filter} = 4'(md);
         for (int n = 0; n < 16; n++) begin
            logic [47:0] da, sa;
            case ($urandom % 3)
               0: da = cfg_da_addr[48*(2*($urandom % 2)) +: 48];
               1: da = {$urandom, 16'($urandom)} | 48'h1;
               default: da = {$urandom, 16'($urandom)} & ~48'h1;
            endcase
            sa = ($urandom % 2) ? cfg_sa_addr[48*($urandom % 2) +: 48] : {$urandom, 16'($urandom)};
            send(da, sa, n == 3);
         end
         hold_check();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule